// File: doc/BRIEF.md
# Two-Stage Priority Bus Arbiter

This block is the central arbiter of a shared word-wide bus to which up to sixty-four units attach. Every unit carries a 7-bit priority that software can change at run time. The priority splits into a group number and a level inside that group. A unit that wants the bus drives one bit of a 4-bit group field and one bit of a 32-bit level field. The units watch the group field themselves and drop out when a higher group is present, so after a settle time only the top group's level bits remain. The arbiter then picks the highest level bit still asserted and broadcasts the complete winning priority as a 7-bit code.

The arbiter drives a 3-bit phase bus that every unit observes. It leaves idle when any request appears and scans for a parameterised number of settle cycles. It then grants for one cycle and holds the transfer phase until the transfer ends. Requests that return data from memory reads, and other transfers of the memory buffer unit, enter on two dedicated inputs. They take two reserved priorities at the top of the highest group, so they beat every ordinary unit. A unit whose traffic is lighter than the bus capacity stops requesting between words, so the bus falls to lower priorities in those gaps.

Top module: `grp_lvl_arbiter`

## Requirements
- R1: The phase bus is encoded as idle = 3'b000, scan = 3'b001, grant = 3'b010 and transfer = 3'b011, and no other value appears. From idle, the arbiter enters scan on the clock edge after any group bit, `memret_req` or `dmabuf_req` is seen high.
- R2: Scan lasts exactly SETTLE cycles (default 3). The decision uses only the group and level fields present in the last scan cycle.
- R3: The winning group is the highest-numbered bit set in the group field, with `memret_req` and `dmabuf_req` counted as requests in group 3.
- R4: The winning level is the highest-numbered bit set in the level field. The code is group*32 + level: the group sits in code bits 6:5 and the level in bits 4:0. A code of 0 (group 0, level 0) is a valid grant.
- R5: If no group bit or no level bit is set at the decision point, the arbiter returns to idle. It issues no grant, and the code output stays 0.
- R6: Grant lasts exactly one cycle with `grant_valid` high, and transfer always follows it. `grant_valid` is high in no other phase.
- R7: Transfer holds, with the code unchanged, until `xfer_done` is high at a clock edge, and then the arbiter returns to idle. `xfer_done` has no effect in any other phase.
- R8: A memory-read return request (`memret_req`) wins with code 127 over every other request.
- R9: A memory buffer transfer request (`dmabuf_req`) wins with code 126 over every unit request and loses only to `memret_req`.
- R10: Level bits 31 and 30 on the bus are reserved for the two buffer requests. When group 3 wins, these bus bits are ignored.
- R11: After reset the phase is idle, `grant_valid` is 0 and the code output is 0.
- R12: When the winner of one round stops requesting, the next round goes to the next-highest remaining requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_field | input | GRP_N (4) | Wired group request field, one bit per group |
| lvl_field | input | LVL_W (32) | Wired level request field of the surviving group |
| memret_req | input | 1 | Memory-read return wants the bus |
| dmabuf_req | input | 1 | Other memory buffer transfer wants the bus |
| xfer_done | input | 1 | Current word transfer has finished |
| bus_state | output | 3 | Broadcast bus phase |
| grant_valid | output | 1 | High during the one-cycle grant phase |
| grant_code | output | 7 | Winning priority, held through grant and transfer, 0 otherwise |

## Verification
The arbiter is driven with these cases:
- a single requester;
- several groups asserted at once;
- group 3 with the reserved bus levels set;
- each buffer request alone, both together, and each mixed with unit requests;
- a group bit with an empty level field.

Separately, these show that group selection, level selection, buffer precedence and reserved-bit masking each work on their own. A round whose level field changes during scan shows that only the final settle cycle is sampled. Two rounds in a row, with the first winner withdrawing, show that the bus falls to the next requester. Idle periods with `xfer_done` high and long transfers show that phase and code ignore stray completion and hold until the real one.

// File: rtl/gla_pkg.sv
package gla_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'b000,
      PH_SCAN  = 3'b001,
      PH_GRANT = 3'b010,
      PH_XFER  = 3'b011
   } bus_phase_e;
endpackage

// File: rtl/gla_prio_enc.sv
// Highest-set-bit encoder of parameterised width.
module gla_prio_enc #(
   parameter int W = 32,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/gla_settle_timer.sv
// Counts the settle cycles of the scan phase; done marks the last one.
module gla_settle_timer #(
   parameter int SETTLE = 3,
   localparam int CW = $clog2(SETTLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(SETTLE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || done)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/gla_field_merge.sv
// Folds the buffer-unit requests into the top group, masks the reserved
// bus levels, and picks the winning group and level.
module gla_field_merge #(
   parameter int GRP_N = 4,
   parameter int LVL_W = 32,
   localparam int GRP_B  = $clog2(GRP_N),
   localparam int LVL_B  = $clog2(LVL_W),
   localparam int CODE_W = GRP_B + LVL_B
) (
   input  logic [GRP_N-1:0]  grp_field,
   input  logic [LVL_W-1:0]  lvl_field,
   input  logic              memret_req,
   input  logic              dmabuf_req,
   output logic              win_any,
   output logic [CODE_W-1:0] win_code
);
   logic             dma_any;
   logic [GRP_N-1:0] grp_eff;
   logic             g_any;
   logic [GRP_B-1:0] g_idx;
   logic             top_rsv;
   logic [LVL_W-1:0] lvl_eff;
   logic             l_any;
   logic [LVL_B-1:0] l_idx;

   assign dma_any = memret_req | dmabuf_req;
   assign grp_eff = grp_field | {dma_any, {(GRP_N-1){1'b0}}};

   gla_prio_enc #(.W(GRP_N)) u_grp_enc (
      .vec (grp_eff),
      .any (g_any),
      .idx (g_idx)
   );

   assign top_rsv = g_any && (g_idx == GRP_B'(GRP_N - 1));

   for (genvar i = 0; i < LVL_W; i++) begin : g_lvl
      if (i == LVL_W - 1) begin : g_memret
         assign lvl_eff[i] = (lvl_field[i] & ~top_rsv) | memret_req;
      end else if (i == LVL_W - 2) begin : g_dmabuf
         assign lvl_eff[i] = (lvl_field[i] & ~top_rsv) | dmabuf_req;
      end else begin : g_unit
         assign lvl_eff[i] = lvl_field[i];
      end
   end

   gla_prio_enc #(.W(LVL_W)) u_lvl_enc (
      .vec (lvl_eff),
      .any (l_any),
      .idx (l_idx)
   );

   assign win_any  = g_any & l_any;
   assign win_code = {g_idx, l_idx};
endmodule

// File: rtl/gla_sequencer.sv
// Bus phase sequencer: idle, scan, grant, transfer.
module gla_sequencer
   import gla_pkg::*;
#(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              decide,
   input  logic              win_any,
   input  logic [CODE_W-1:0] win_code,
   input  logic              xfer_done,
   output bus_phase_e        phase,
   output logic [CODE_W-1:0] code_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         code_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE:  if (start) phase <= PH_SCAN;
            PH_SCAN:  if (decide) begin
                         if (win_any) begin
                            code_q <= win_code;
                            phase  <= PH_GRANT;
                         end else begin
                            phase  <= PH_IDLE;
                         end
                      end
            PH_GRANT: phase <= PH_XFER;
            PH_XFER:  if (xfer_done) phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/grp_lvl_arbiter.sv
module grp_lvl_arbiter
   import gla_pkg::*;
#(
   parameter int GRP_N  = 4,
   parameter int LVL_W  = 32,
   parameter int SETTLE = 3,
   localparam int GRP_B  = $clog2(GRP_N),
   localparam int LVL_B  = $clog2(LVL_W),
   localparam int CODE_W = GRP_B + LVL_B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GRP_N-1:0]  grp_field,
   input  logic [LVL_W-1:0]  lvl_field,
   input  logic              memret_req,
   input  logic              dmabuf_req,
   input  logic              xfer_done,
   output logic [2:0]        bus_state,
   output logic              grant_valid,
   output logic [CODE_W-1:0] grant_code
);
   if (GRP_N < 2 || (1 << GRP_B) != GRP_N) begin : g_bad_grp
      $error("GRP_N must be a power of two, at least 2");
   end
   if (LVL_W < 4 || (1 << LVL_B) != LVL_W) begin : g_bad_lvl
      $error("LVL_W must be a power of two, at least 4");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end

   bus_phase_e        phase;
   logic [CODE_W-1:0] code_q;
   logic              decide;
   logic              win_any;
   logic [CODE_W-1:0] win_code;
   logic              start;

   assign start = (|grp_field) | memret_req | dmabuf_req;

   gla_settle_timer #(.SETTLE(SETTLE)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (phase == PH_SCAN),
      .done  (decide)
   );

   gla_field_merge #(.GRP_N(GRP_N), .LVL_W(LVL_W)) u_merge (
      .grp_field  (grp_field),
      .lvl_field  (lvl_field),
      .memret_req (memret_req),
      .dmabuf_req (dmabuf_req),
      .win_any    (win_any),
      .win_code   (win_code)
   );

   gla_sequencer #(.CODE_W(CODE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .decide    (decide),
      .win_any   (win_any),
      .win_code  (win_code),
      .xfer_done (xfer_done),
      .phase     (phase),
      .code_q    (code_q)
   );

   assign bus_state   = phase;
   assign grant_valid = (phase == PH_GRANT);
   assign grant_code  = (phase == PH_GRANT || phase == PH_XFER) ? code_q : '0;
endmodule

// File: rtl/grp_lvl_arbiter_chk.sv
module grp_lvl_arbiter_chk #(
   parameter int GRP_N  = 4,
   parameter int LVL_W  = 32,
   parameter int SETTLE = 3,
   localparam int GRP_B  = $clog2(GRP_N),
   localparam int LVL_B  = $clog2(LVL_W),
   localparam int CODE_W = GRP_B + LVL_B
) (
   input logic              clk,
   input logic              rst_n,
   input logic              memret_req,
   input logic              dmabuf_req,
   input logic              xfer_done,
   input logic [2:0]        bus_state,
   input logic              grant_valid,
   input logic [CODE_W-1:0] grant_code
);
   int scan_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 scan_len <= 0;
      else if (bus_state == 3'd1) scan_len <= scan_len + 1;
      else                        scan_len <= 0;
   end

   // R1
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state <= 3'd3);

   // R2
   scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd1) |-> (scan_len < SETTLE));

   // R2
   scan_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_state) == 3'd1 && bus_state != 3'd1) |-> ($past(scan_len) == SETTLE - 1));

   // R6
   grant_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |=> (bus_state == 3'd3 && !grant_valid));

   // R5
   grant_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> ($past(bus_state) == 3'd1));

   // R7
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == 3'd3 && !xfer_done) |=> (bus_state == 3'd3 && $stable(grant_code)));

   // R8
   memret_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(memret_req)) |-> (grant_code == CODE_W'((1 << CODE_W) - 1)));

   // R9
   dmabuf_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !$past(memret_req) && $past(dmabuf_req))
         |-> (grant_code == CODE_W'((1 << CODE_W) - 2)));

   // R10
   reserved_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && grant_code[CODE_W-1 -: GRP_B] == GRP_B'(GRP_N - 1)
         && !$past(memret_req) && !$past(dmabuf_req))
         |-> (grant_code[LVL_B-1:0] < LVL_B'(LVL_W - 2)));
endmodule

bind grp_lvl_arbiter grp_lvl_arbiter_chk #(
   .GRP_N (GRP_N),
   .LVL_W (LVL_W),
   .SETTLE(SETTLE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .memret_req  (memret_req),
   .dmabuf_req  (dmabuf_req),
   .xfer_done   (xfer_done),
   .bus_state   (bus_state),
   .grant_valid (grant_valid),
   .grant_code  (grant_code)
);

// File: tb/tb_grp_lvl_arbiter.sv
`timescale 1ns/1ps
module tb_grp_lvl_arbiter;
   localparam int SETTLE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  grp_field = '0;
   logic [31:0] lvl_field = '0;
   logic        memret_req = 1'b0;
   logic        dmabuf_req = 1'b0;
   logic        xfer_done = 1'b0;
   logic [2:0]  bus_state;
   logic        grant_valid;
   logic [6:0]  grant_code;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int m_st = 0;
   int m_cnt = 0;
   int m_code = 0;

   always #2.5 clk = ~clk;

   grp_lvl_arbiter #(.GRP_N(4), .LVL_W(32), .SETTLE(SETTLE)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .grp_field   (grp_field),
      .lvl_field   (lvl_field),
      .memret_req  (memret_req),
      .dmabuf_req  (dmabuf_req),
      .xfer_done   (xfer_done),
      .bus_state   (bus_state),
      .grant_valid (grant_valid),
      .grant_code  (grant_code)
   );

   function automatic int pick(input logic [3:0] g, input logic [31:0] l,
                               input logic mr, input logic db);
      int grp;
      int lv;
      logic [3:0] ge;
      logic [31:0] le;
      grp = -1;
      lv = -1;
      ge = g;
      if (mr || db) ge[3] = 1'b1;
      for (int i = 0; i < 4; i++) if (ge[i]) grp = i;
      if (grp < 0) return -1;
      le = l;
      if (grp == 3) begin
         le[31] = 1'b0;
         le[30] = 1'b0;
      end
      if (mr) le[31] = 1'b1;
      if (db) le[30] = 1'b1;
      for (int i = 0; i < 32; i++) if (le[i]) lv = i;
      if (lv < 0) return -1;
      return grp * 32 + lv;
   endfunction

   // Behavioural reference model, updated on each rising edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0;
         m_cnt = 0;
         m_code = 0;
      end else begin
         case (m_st)
            0: begin
               m_cnt = 0;
               if (grp_field != 0 || memret_req || dmabuf_req) m_st = 1;
            end
            1: begin
               if (m_cnt == SETTLE - 1) begin
                  int p;
                  p = pick(grp_field, lvl_field, memret_req, dmabuf_req);
                  m_cnt = 0;
                  if (p < 0) m_st = 0;
                  else begin
                     m_code = p;
                     m_st = 2;
                  end
               end else m_cnt = m_cnt + 1;
            end
            2: m_st = 3;
            default: if (xfer_done) m_st = 0;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic tick();
      int exp_code;
      @(negedge clk);
      exp_code = (m_st == 2 || m_st == 3) ? m_code : 0;
      chk("R1 phase vs model", 32'(bus_state), 32'(m_st));
      chk("R6 grant strobe vs model", 32'(grant_valid), 32'(m_st == 2));
      chk("R4 code vs model", 32'(grant_code), 32'(exp_code));
   endtask

   task automatic drive(input logic [3:0] g, input logic [31:0] l,
                        input logic mr, input logic db);
      grp_field = g;
      lvl_field = l;
      memret_req = mr;
      dmabuf_req = db;
   endtask

   // Present a request and advance to the expected grant cycle.
   task automatic round(input logic [3:0] g, input logic [31:0] l,
                        input logic mr, input logic db);
      drive(g, l, mr, db);
      repeat (1 + SETTLE) tick();
   endtask

   task automatic finish_xfer(input int hold);
      drive('0, '0, 1'b0, 1'b0);
      tick();
      chk("R6 transfer follows grant", 32'(bus_state), 32'd3);
      repeat (hold) begin
         tick();
         chk("R7 transfer held", 32'(bus_state), 32'd3);
      end
      xfer_done = 1'b1;
      tick();
      chk("R7 idle after done", 32'(bus_state), 32'd0);
      xfer_done = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: got %0d cycles expected fewer than 20000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset phase", 32'(bus_state), 32'd0);
      chk("R11 reset grant_valid", 32'(grant_valid), 32'd0);
      chk("R11 reset code", 32'(grant_code), 32'd0);
      rst_n = 1'b1;
      tick();

      // R1, R4: single requester group 1 level 5 -> 37
      drive(4'b0010, 32'h1 << 5, 1'b0, 1'b0);
      tick();
      chk("R1 scan entered", 32'(bus_state), 32'd1);
      repeat (SETTLE) tick();
      chk("R4 single requester code", 32'(grant_code), 32'd37);
      chk("R6 grant strobe", 32'(grant_valid), 32'd1);
      finish_xfer(3);

      // R3: groups 0 and 2 asserted, levels 7 and 3 -> 2*32+7 = 71
      round(4'b0101, (32'h1 << 7) | (32'h1 << 3), 1'b0, 1'b0);
      chk("R3 highest group wins", 32'(grant_code), 32'd71);
      finish_xfer(1);

      // R10: group 3 with reserved bus levels 31,30 and level 12 -> 108
      round(4'b1000, 32'hC000_0000 | (32'h1 << 12), 1'b0, 1'b0);
      chk("R10 reserved bus levels ignored", 32'(grant_code), 32'd108);
      finish_xfer(0);

      // R8: memory-read return beats group 3 level 29 -> 127
      round(4'b1000, 32'h1 << 29, 1'b1, 1'b0);
      chk("R8 memret wins", 32'(grant_code), 32'd127);
      finish_xfer(0);

      // R9: buffer transfer beats unit -> 126
      round(4'b1100, 32'h1 << 29, 1'b0, 1'b1);
      chk("R9 dmabuf wins over units", 32'(grant_code), 32'd126);
      finish_xfer(0);

      // R8, R9: both buffer requests -> 127
      round(4'b0000, 32'h0, 1'b1, 1'b1);
      chk("R8 memret beats dmabuf", 32'(grant_code), 32'd127);
      finish_xfer(0);

      // R9 alone with no unit requests -> 126
      round(4'b0000, 32'h0, 1'b0, 1'b1);
      chk("R9 dmabuf alone", 32'(grant_code), 32'd126);
      finish_xfer(0);

      // R5: group bit but empty level field -> back to idle, no grant
      round(4'b0100, 32'h0, 1'b0, 1'b0);
      chk("R5 no grant phase", 32'(bus_state), 32'd0);
      chk("R5 no grant strobe", 32'(grant_valid), 32'd0);
      chk("R5 code stays zero", 32'(grant_code), 32'd0);
      drive('0, '0, 1'b0, 1'b0);
      tick();

      // R7: xfer_done while idle has no effect
      xfer_done = 1'b1;
      repeat (3) begin
         tick();
         chk("R7 done ignored in idle", 32'(bus_state), 32'd0);
      end
      xfer_done = 1'b0;

      // R2: level changes during scan; only the last settle cycle counts -> 41
      drive(4'b0010, 32'h1 << 3, 1'b0, 1'b0);
      repeat (SETTLE) tick();
      chk("R2 still scanning", 32'(bus_state), 32'd1);
      lvl_field = 32'h1 << 9;
      tick();
      chk("R2 last settle cycle sampled", 32'(grant_code), 32'd41);
      finish_xfer(0);

      // R12: winner withdraws, next requester gets the following round
      round(4'b0110, 32'h1 << 4, 1'b0, 1'b0);
      chk("R12 first round higher group", 32'(grant_code), 32'd68);
      finish_xfer(0);
      round(4'b0010, 32'h1 << 9, 1'b0, 1'b0);
      chk("R12 second round next requester", 32'(grant_code), 32'd41);
      finish_xfer(0);

      // R4: group 0 level 0 is a valid grant with code 0
      round(4'b0001, 32'h1, 1'b0, 1'b0);
      chk("R4 zero code granted", 32'(grant_valid), 32'd1);
      chk("R4 zero code value", 32'(grant_code), 32'd0);
      finish_xfer(2);

      repeat (2) tick();
      summary();
      $finish;
   end
endmodule